// File: doc/BRIEF.md
# Interrupt Pending and Arbitration Unit

This unit sits beside the sequencer of a small 8-bit processor and decides, once per completed instruction, whether exception processing begins and which vector address the core must fetch. Four maskable hardware sources (external request pin, multi-function timer, bus interface, sync-signal processor) each raise a request line. Requests are caught in pending flags and kept until they are serviced. The flags are looked at only when the core signals that an instruction has finished. The current value of the mask bit from the condition-code register gates all four sources.

A software-interrupt opcode works differently. When the core fetches it, the core pulses a strobe. The unit arms a non-maskable request and records a snapshot of the hardware sources that were pending and unmasked at that moment. Those sources are serviced ahead of the software interrupt. Anything that becomes pending after the fetch waits until the software interrupt has been taken. Each decision is issued one clock after the boundary strobe: a take pulse, the vector address (high-byte location), and a command for the core to set its mask bit.

Top module: `exc_arbiter`

## Requirements
- R1: While reset is held and in the cycle after it is released, take_exc, set_imask and vec_addr are all 0, and no source is pending.
- R2: A request held high for a single cycle stays pending until its vector is issued, however many cycles pass before the next eligible boundary.
- R3: take_exc is high only in the cycle right after a cycle with insn_done high. A request that first appears in the same cycle as insn_done is not seen at that boundary.
- R4: While i_mask is 1 at a boundary, no hardware vector is issued. The requests stay pending and are taken at the first boundary where i_mask is 0.
- R5: When several maskable sources are eligible together, hw_req[0] (pin) wins over hw_req[1] (timer), which wins over hw_req[2] (bus interface), which wins over hw_req[3] (sync processor).
- R6: The software-interrupt vector is 0x3FFC. The vector for hw_req[k] is 0x3FFA − 2k, which gives 0x3FFA, 0x3FF8, 0x3FF6 and 0x3FF4. vec_addr is 0 in every cycle without a take.
- R7: set_imask is high exactly in the cycles where take_exc is high.
- R8: Issuing a source's vector clears only that source's pending flag. Other pending sources are taken at later boundaries.
- R9: After swi_fetch, the software vector is issued at the first boundary where no snapshot source is still eligible, whatever the value of i_mask.
- R10: Hardware sources that were pending when swi_fetch pulsed with i_mask 0 are issued, in priority order, at boundaries before the software vector.
- R11: A request arriving in the cycle of swi_fetch or later, even one of higher priority, is issued only after the software vector.
- R12: At a boundary with nothing eligible and no software request armed, take_exc stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | NUM_HW | Hardware request lines, bit 0 highest priority |
| i_mask | input | 1 | Mask bit from the condition-code register |
| insn_done | input | 1 | Instruction-complete strobe (boundary) |
| swi_fetch | input | 1 | Software-interrupt opcode fetched strobe |
| take_exc | output | 1 | Start exception processing (one-cycle pulse) |
| vec_addr | output | ADDR_W | Address of the high byte of the selected vector |
| set_imask | output | 1 | Command to set the mask bit |

## Verification
The bench uses the default parameters: four hardware sources and 16-bit vectors with the top vector at 0x3FFC. With these defaults every one of the sixteen pending patterns and every pairing of snapshot and late arrivals around a software fetch can be reached. Directed sequences cover priority draining, masking with retention, same-cycle arrivals and the ordering around the software interrupt. A long random phase then compares every output on every clock against a behavioural model.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_HW   = 2'd1,
        PICK_SWI  = 2'd2
    } pick_e;
endpackage

// File: rtl/exc_pend_bank.sv
module exc_pend_bank #(
    parameter int NUM_HW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_HW-1:0] req,
    input  logic [NUM_HW-1:0] clr,
    input  logic              snap_en,
    input  logic              snap_allow,
    input  logic              pre_drop,
    output logic [NUM_HW-1:0] pend,
    output logic [NUM_HW-1:0] pre
);
    typedef struct packed {
        logic [NUM_HW-1:0] pend;
        logic [NUM_HW-1:0] pre;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~clr) | req;
        st_d.pre  = st_q.pre & ~clr;
        if (pre_drop) begin
            st_d.pre = '0;
        end
        if (snap_en) begin
            st_d.pre = snap_allow ? (st_q.pend & ~clr) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
    assign pre  = st_q.pre;

    // R8: a cleared flag without a fresh request is gone on the next cycle
    p_clear_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~req) != '0) |=> ((st_q.pend & $past(clr & ~req)) == '0));

    // R2: a request is pending one cycle later
    p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |=> ((st_q.pend & $past(req)) == $past(req)));
endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
    parameter int NUM_HW = 4,
    localparam int IDX_W = (NUM_HW > 1) ? $clog2(NUM_HW) : 1
) (
    input  logic [NUM_HW-1:0] cand,
    output logic [NUM_HW-1:0] grant,
    output logic              any,
    output logic [IDX_W-1:0]  idx
);
    genvar g;
    generate
        for (g = 0; g < NUM_HW; g++) begin : g_lane
            if (g == 0) begin : g_top
                assign grant[g] = cand[g];
            end else begin : g_low
                assign grant[g] = cand[g] & ~(|cand[g-1:0]);
            end
        end
    endgenerate

    assign any = |cand;

    always_comb begin
        idx = '0;
        for (int k = 0; k < NUM_HW; k++) begin
            if (grant[k]) begin
                idx = idx | IDX_W'(k);
            end
        end
    end

    // R5: at most one winner, and only among candidates
    always_comb begin
        p_grant_onehot_r5: assert ($onehot0(grant) && ((grant & ~cand) == '0));
    end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int                NUM_HW  = 4,
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] VEC_TOP = 16'h3FFC,
    localparam int IDX_W = (NUM_HW > 1) ? $clog2(NUM_HW) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_HW-1:0] hw_req,
    input  logic              i_mask,
    input  logic              insn_done,
    input  logic              swi_fetch,
    output logic              take_exc,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              set_imask
);
    typedef struct packed {
        logic              take;
        logic              seti;
        logic [ADDR_W-1:0] vec;
        logic              armed;
    } arb_t;

    arb_t              st_d, st_q;
    pick_e             pick;
    logic [NUM_HW-1:0] pend, pre, cand, grant, clr;
    logic              any;
    logic [IDX_W-1:0]  idx;

    exc_pend_bank #(.NUM_HW(NUM_HW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (hw_req),
        .clr        (clr),
        .snap_en    (swi_fetch),
        .snap_allow (~i_mask),
        .pre_drop   (pick == PICK_SWI),
        .pend       (pend),
        .pre        (pre)
    );

    exc_prio_pick #(.NUM_HW(NUM_HW)) u_pick (
        .cand  (cand),
        .grant (grant),
        .any   (any),
        .idx   (idx)
    );

    always_comb begin
        cand = i_mask ? '0 : (st_q.armed ? (pend & pre) : pend);
        pick = PICK_NONE;
        if (insn_done) begin
            if (any) begin
                pick = PICK_HW;
            end else if (st_q.armed) begin
                pick = PICK_SWI;
            end
        end
        clr = (pick == PICK_HW) ? grant : '0;

        st_d       = st_q;
        st_d.take  = (pick != PICK_NONE);
        st_d.seti  = (pick != PICK_NONE);
        st_d.armed = swi_fetch | (st_q.armed & (pick != PICK_SWI));
        case (pick)
            PICK_SWI: st_d.vec = VEC_TOP;
            PICK_HW:  st_d.vec = VEC_TOP - ADDR_W'({idx, 1'b0}) - ADDR_W'(2);
            default:  st_d.vec = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_exc  = st_q.take;
    assign set_imask = st_q.seti;
    assign vec_addr  = st_q.vec;

    // R3: decisions appear only one cycle after a boundary
    p_boundary_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |-> $past(insn_done));

    // R4: a hardware vector never follows a masked boundary
    p_hw_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && vec_addr != VEC_TOP) |-> !$past(i_mask));

    // R9: an armed request with the mask set is served at the boundary
    p_swi_served_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && i_mask && st_q.armed) |=> (take_exc && vec_addr == VEC_TOP));

    // R12: nothing eligible means no take
    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && !st_q.armed && (i_mask || pend == '0)) |=> !take_exc);

    // R7: the mask command accompanies each take
    p_seti_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_exc) |-> $rose(set_imask));
endmodule

// File: tb/sim_exc_arbiter.sv
module sim_exc_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  hw_req = '0;
    logic        i_mask = 1'b0;
    logic        insn_done = 1'b0;
    logic        swi_fetch = 1'b0;
    logic        take_exc;
    logic [15:0] vec_addr;
    logic        set_imask;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #10 clk = ~clk;

    exc_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .i_mask(i_mask),
        .insn_done(insn_done), .swi_fetch(swi_fetch),
        .take_exc(take_exc), .vec_addr(vec_addr), .set_imask(set_imask)
    );

    // behavioural reference model
    bit [3:0]  m_pend, m_pre;
    bit        m_armed;
    bit        e_take, e_seti;
    bit [15:0] e_vec;

    always @(posedge clk) begin
        int found;
        if (!rst_n) begin
            m_pend = 0; m_pre = 0; m_armed = 0;
            e_take = 0; e_seti = 0; e_vec = 0;
        end else begin
            found = -1;
            e_take = 0; e_seti = 0; e_vec = 0;
            if (insn_done) begin
                for (int k = 0; k < 4; k++)
                    if (found < 0 && !i_mask && m_pend[k] && (!m_armed || m_pre[k]))
                        found = k;
                if (found >= 0) begin
                    e_take = 1; e_seti = 1;
                    e_vec = 16'h3FFA - 16'(2 * found);
                    m_pend[found] = 0;
                    m_pre[found] = 0;
                end else if (m_armed) begin
                    e_take = 1; e_seti = 1; e_vec = 16'h3FFC;
                    m_armed = 0; m_pre = 0;
                end
            end
            if (swi_fetch) begin
                m_armed = 1;
                m_pre = i_mask ? 4'b0 : m_pend;
            end
            m_pend = m_pend | hw_req;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !ended) begin
            chk("R3 take_exc vs model", take_exc, e_take);
            chk("R6 vec_addr vs model", vec_addr, e_vec);
            chk("R7 set_imask vs model", set_imask, e_seti);
        end
    end

    task automatic cyc(input logic [3:0] r, input logic m, input logic d, input logic s);
        hw_req = r; i_mask = m; insn_done = d; swi_fetch = s;
        @(negedge clk);
    endtask

    task automatic bound(input logic m, input logic et, input logic [15:0] ev, input string tag);
        cyc(4'h0, m, 1'b1, 1'b0);
        chk({tag, " take"}, take_exc, et);
        chk({tag, " vec"}, vec_addr, ev);
        cyc(4'h0, m, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 take in reset", take_exc, 0);
        chk("R1 seti in reset", set_imask, 0);
        chk("R1 vec in reset", vec_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 take after reset", take_exc, 0);
        bound(0, 0, 16'h0, "R12 idle boundary");

        // R2: one-cycle pulse survives idle cycles
        cyc(4'b0100, 0, 0, 0);
        repeat (3) begin
            cyc(4'h0, 0, 0, 0);
            chk("R3 no take off boundary", take_exc, 0);
        end
        bound(0, 1, 16'h3FF6, "R2 held request");

        // R5/R8: all four together drain in order
        cyc(4'b1111, 0, 0, 0);
        bound(0, 1, 16'h3FFA, "R5 first");
        bound(0, 1, 16'h3FF8, "R8 second");
        bound(0, 1, 16'h3FF6, "R8 third");
        bound(0, 1, 16'h3FF4, "R5 fourth");
        bound(0, 0, 16'h0, "R12 drained");

        // R4: masked then released
        cyc(4'b0001, 1, 0, 0);
        bound(1, 0, 16'h0, "R4 masked");
        bound(0, 1, 16'h3FFA, "R4 released");

        // R3: arrival with the boundary is not seen
        cyc(4'b0010, 0, 1, 0);
        chk("R3 same-cycle arrival", take_exc, 0);
        cyc(4'h0, 0, 0, 0);
        bound(0, 1, 16'h3FF8, "R3 next boundary");

        // R9: software request under mask
        cyc(4'h0, 1, 0, 1);
        bound(1, 1, 16'h3FFC, "R9 swi masked");

        // R10/R11: snapshot first, software next, later arrival last
        cyc(4'b1000, 0, 0, 0);
        cyc(4'h0, 0, 0, 1);
        cyc(4'b0001, 0, 0, 0);
        bound(0, 1, 16'h3FF4, "R10 snapshot first");
        bound(0, 1, 16'h3FFC, "R10 swi second");
        bound(0, 1, 16'h3FFA, "R11 late arrival");

        // R11: arrival in the fetch cycle
        cyc(4'b0010, 0, 0, 1);
        bound(0, 1, 16'h3FFC, "R11 swi before same-cycle");
        bound(0, 1, 16'h3FF8, "R11 same-cycle after");

        // random phase checked against the model every clock
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] r;
            r = '0;
            for (int k = 0; k < 4; k++) r[k] = ($urandom_range(0, 15) == 0);
            cyc(r, ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0),
                ($urandom_range(0, 19) == 0));
        end
        cyc(4'h0, 0, 0, 0);
        finish_run();
    end
endmodule